// File: doc/BRIEF.md
# Bus Cycle Arbiter and Sequencer

This block is the central control state machine of a network-controller expansion card. It watches three request sources: the controller's DMA hold request, the controller's interrupt line and host CPU I/O requests. From idle it grants one of them and then runs one of eleven non-idle cycle types. While a cycle runs it drives the controller handshakes (hold acknowledge, controller strobe) and the host bus handshakes (bus request, read/write, data strobe). It also raises the CPU interrupt at the right point of the interrupt-service chain.

The current cycle type appears as a 4-bit code and the position inside the cycle as a 3-bit step count, so that downstream timing logic can decode both. A separate flag marks on-board accesses that do not involve the controller. DMA transfers chain back to back while the hold request stays high. An interrupt runs three linked cycles that never pass through idle. All control pins are plain levels; no data path passes through this block.

Top module: `bus_cycle_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) forces cycle code 0 (idle) and step 0, and deasserts `hold_ack`, `bus_req`, `bus_ds`, `ctl_strobe`, `cpu_irq` and `io_cycle`.
- R2: From idle, the grant follows fixed priority: `ctl_irq` first, then `ctl_hold`, then `cpu_req`. The chosen cycle's code shows on `cycle_type` one clock after the request is seen in idle.
- R3: CPU operation codes on `cpu_op` map to cycle codes as follows: 0 on-board read → 1, 1 on-board write → 2, 2 controller read → 3, 3 controller write → 4, 4 latch read → 5. A CPU cycle starts only from idle and always ends in idle. `io_cycle` is high exactly during codes 1, 2 and 5.
- R4: A granted hold request first runs the synchronization cycle (code 6). When that cycle ends, the machine goes straight to DMA read (code 7, `ctl_dma_wr`=0) or DMA write (code 8, `ctl_dma_wr`=1) without idle. `hold_ack` is high during codes 7 and 8.
- R5: When a DMA cycle ends with `ctl_hold` still high, the next DMA cycle follows immediately. A burst of eight transfers therefore runs as eight consecutive DMA cycles with no idle in between. When `ctl_hold` is low at the end of a DMA cycle, the machine returns to idle.
- R6: A granted interrupt runs status read (code 9), status DMA (code 10) and status write-back (code 11) in that order, then returns to idle, with no idle between the three.
- R7: `cpu_irq` is high exactly while the status write-back cycle (code 11) runs.
- R8: `step` starts at 0 in every cycle. It advances only on clocks where the cycle's pacing handshake is high: `ctl_ready` for codes 3, 4, 9 and 11; `bus_ready` for codes 6, 7, 8 and 10; always for codes 1, 2 and 5. A cycle ends on the advancing clock at step `LAST_STEP` (default 3).
- R9: `bus_req` is high during codes 6, 7, 8 and 10. `bus_rw` is 1 (read) in code 7 and 0 (write) in codes 8 and 10. `ctl_strobe` is high in codes 3, 4, 9 and 11 once step is nonzero.
- R10: A CPU request with an unassigned `cpu_op` value (5 to 7) is ignored: the machine stays idle with all handshakes low.
- R11: A CPU request that arrives while another cycle runs waits. It starts from the idle clock that follows the end of that activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_hold | input | 1 | Controller DMA hold request |
| ctl_dma_wr | input | 1 | DMA direction: 1 write to memory, 0 read from memory |
| ctl_irq | input | 1 | Controller interrupt request |
| ctl_ready | input | 1 | Controller ready handshake |
| cpu_req | input | 1 | Host CPU I/O request |
| cpu_op | input | 3 | Host CPU operation code |
| bus_ready | input | 1 | Host bus ready handshake |
| hold_ack | output | 1 | Hold acknowledge to controller |
| ctl_strobe | output | 1 | Controller access strobe |
| bus_req | output | 1 | Host bus request |
| bus_rw | output | 1 | Host bus direction, 1 read |
| bus_ds | output | 1 | Host bus data strobe |
| cpu_irq | output | 1 | Interrupt to host CPU |
| io_cycle | output | 1 | On-board non-controller access in progress |
| cycle_type | output | 4 | Current cycle code |
| step | output | 3 | Step count within the current cycle |

## Verification
A vector table drives single requests and combinations of simultaneous requests from idle. Single requests confirm each code mapping; combined requests separate the priority order from plain decoding, and an unassigned operation code shows it is ignored. Directed runs hold the ready handshakes low to tell paced cycles from free-running ones. One run holds the hold request through eight transfers to confirm chaining with no idle, and one follows the full interrupt chain together with the CPU interrupt. A CPU request raised during a DMA transfer shows that waiting for idle differs from preemption.

// File: rtl/cyc_pkg.sv
package cyc_pkg;

  typedef enum logic [3:0] {
    CY_IDLE     = 4'd0,
    CY_LOC_RD   = 4'd1,
    CY_LOC_WR   = 4'd2,
    CY_CTL_RD   = 4'd3,
    CY_CTL_WR   = 4'd4,
    CY_LATCH_RD = 4'd5,
    CY_DMA_SYNC = 4'd6,
    CY_DMA_RD   = 4'd7,
    CY_DMA_WR   = 4'd8,
    CY_ST_RD    = 4'd9,
    CY_ST_DMA   = 4'd10,
    CY_ST_WR    = 4'd11
  } cyc_t;

  typedef enum logic [1:0] {
    PACE_FREE = 2'd0,
    PACE_CTL  = 2'd1,
    PACE_BUS  = 2'd2
  } pace_t;

  function automatic pace_t pace_of(cyc_t c);
    case (c)
      CY_CTL_RD, CY_CTL_WR, CY_ST_RD, CY_ST_WR:        return PACE_CTL;
      CY_DMA_SYNC, CY_DMA_RD, CY_DMA_WR, CY_ST_DMA:    return PACE_BUS;
      default:                                          return PACE_FREE;
    endcase
  endfunction

  function automatic logic is_cpu(cyc_t c);
    return (c == CY_LOC_RD) || (c == CY_LOC_WR) || (c == CY_CTL_RD) ||
           (c == CY_CTL_WR) || (c == CY_LATCH_RD);
  endfunction

endpackage

// File: rtl/cyc_arbiter.sv
module cyc_arbiter
  import cyc_pkg::*;
(
  input  logic       irq,
  input  logic       hold,
  input  logic       cpu_req,
  input  logic [2:0] cpu_op,
  output cyc_t       start_cyc
);

  cyc_t cpu_cyc;

  always_comb begin
    case (cpu_op)
      3'd0:    cpu_cyc = CY_LOC_RD;
      3'd1:    cpu_cyc = CY_LOC_WR;
      3'd2:    cpu_cyc = CY_CTL_RD;
      3'd3:    cpu_cyc = CY_CTL_WR;
      3'd4:    cpu_cyc = CY_LATCH_RD;
      default: cpu_cyc = CY_IDLE;
    endcase
  end

  always_comb begin
    if (irq)          start_cyc = CY_ST_RD;
    else if (hold)    start_cyc = CY_DMA_SYNC;
    else if (cpu_req) start_cyc = cpu_cyc;
    else              start_cyc = CY_IDLE;
  end

endmodule

// File: rtl/cyc_timer.sv
module cyc_timer #(
  parameter int STEP_W    = 3,
  parameter int LAST_STEP = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              advance,
  output logic [STEP_W-1:0] step,
  output logic              done
);

  localparam logic [STEP_W-1:0] LAST = LAST_STEP[STEP_W-1:0];

  assign done = busy && advance && (step == LAST);

  always_ff @(posedge clk) begin
    if (rst)                step <= '0;
    else if (!busy || done) step <= '0;
    else if (advance)       step <= step + 1'b1;
  end

endmodule

// File: rtl/cyc_decode.sv
module cyc_decode
  import cyc_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  cyc_t              cyc,
  input  logic [STEP_W-1:0] step,
  output logic              hold_ack,
  output logic              ctl_strobe,
  output logic              bus_req,
  output logic              bus_rw,
  output logic              bus_ds,
  output logic              cpu_irq,
  output logic              io_cycle
);

  logic moving;
  assign moving = (step != '0);

  always_comb begin
    hold_ack   = (cyc == CY_DMA_RD) || (cyc == CY_DMA_WR);
    bus_req    = (pace_of(cyc) == PACE_BUS);
    bus_rw     = !((cyc == CY_DMA_WR) || (cyc == CY_ST_DMA));
    bus_ds     = bus_req && (cyc != CY_DMA_SYNC) && moving;
    ctl_strobe = (pace_of(cyc) == PACE_CTL) && moving;
    cpu_irq    = (cyc == CY_ST_WR);
    io_cycle   = (cyc == CY_LOC_RD) || (cyc == CY_LOC_WR) || (cyc == CY_LATCH_RD);
  end

endmodule

// File: rtl/bus_cycle_sequencer.sv
module bus_cycle_sequencer
  import cyc_pkg::*;
#(
  parameter int STEP_W    = 3,
  parameter int LAST_STEP = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_hold,
  input  logic              ctl_dma_wr,
  input  logic              ctl_irq,
  input  logic              ctl_ready,
  input  logic              cpu_req,
  input  logic [2:0]        cpu_op,
  input  logic              bus_ready,
  output logic              hold_ack,
  output logic              ctl_strobe,
  output logic              bus_req,
  output logic              bus_rw,
  output logic              bus_ds,
  output logic              cpu_irq,
  output logic              io_cycle,
  output logic [3:0]        cycle_type,
  output logic [STEP_W-1:0] step
);

  cyc_t state, nxt, start_cyc, dma_kind;
  logic busy, advance, done;

  cyc_arbiter u_arb (
    .irq       (ctl_irq),
    .hold      (ctl_hold),
    .cpu_req   (cpu_req),
    .cpu_op    (cpu_op),
    .start_cyc (start_cyc)
  );

  assign busy     = (state != CY_IDLE);
  assign dma_kind = ctl_dma_wr ? CY_DMA_WR : CY_DMA_RD;

  always_comb begin
    case (pace_of(state))
      PACE_CTL: advance = ctl_ready;
      PACE_BUS: advance = bus_ready;
      default:  advance = 1'b1;
    endcase
  end

  cyc_timer #(.STEP_W(STEP_W), .LAST_STEP(LAST_STEP)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .advance (advance),
    .step    (step),
    .done    (done)
  );

  always_comb begin
    nxt = state;
    if (!busy) begin
      nxt = start_cyc;
    end else if (done) begin
      case (state)
        CY_DMA_SYNC:          nxt = dma_kind;
        CY_DMA_RD, CY_DMA_WR: nxt = ctl_hold ? dma_kind : CY_IDLE;
        CY_ST_RD:             nxt = CY_ST_DMA;
        CY_ST_DMA:            nxt = CY_ST_WR;
        default:              nxt = CY_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= CY_IDLE;
    else     state <= nxt;
  end

  cyc_decode #(.STEP_W(STEP_W)) u_dec (
    .cyc        (state),
    .step       (step),
    .hold_ack   (hold_ack),
    .ctl_strobe (ctl_strobe),
    .bus_req    (bus_req),
    .bus_rw     (bus_rw),
    .bus_ds     (bus_ds),
    .cpu_irq    (cpu_irq),
    .io_cycle   (io_cycle)
  );

  assign cycle_type = state;

endmodule

// File: rtl/cyc_checker.sv
module cyc_checker #(
  parameter int STEP_W    = 3,
  parameter int LAST_STEP = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        cycle_type,
  input logic [STEP_W-1:0] step,
  input logic              ctl_ready,
  input logic              cpu_irq
);

  localparam logic [STEP_W-1:0] LAST = LAST_STEP[STEP_W-1:0];

  AST_SYNC_THEN_XFER: assert property (@(posedge clk) disable iff (rst)
    (cycle_type == 4'd6) |=> (cycle_type inside {4'd6, 4'd7, 4'd8})); // R4

  AST_STATUS_READ_NEXT: assert property (@(posedge clk) disable iff (rst)
    (cycle_type == 4'd9) |=> (cycle_type inside {4'd9, 4'd10})); // R6

  AST_STATUS_DMA_NEXT: assert property (@(posedge clk) disable iff (rst)
    (cycle_type == 4'd10) |=> (cycle_type inside {4'd10, 4'd11})); // R6

  AST_IRQ_ALIGN: assert property (@(posedge clk) disable iff (rst)
    cpu_irq == (cycle_type == 4'd11)); // R7

  AST_CTL_WAIT: assert property (@(posedge clk) disable iff (rst)
    (cycle_type == 4'd3 && !ctl_ready) |=> (cycle_type == 4'd3 && $stable(step))); // R8

  AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (rst)
    step <= LAST); // R8

  AST_CPU_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$stable(cycle_type) && cycle_type inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5})
      |-> ($past(cycle_type) == 4'd0)); // R3

  AST_CPU_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cycle_type inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5})
      |=> (cycle_type == $past(cycle_type) || cycle_type == 4'd0)); // R3

endmodule

bind bus_cycle_sequencer cyc_checker #(.STEP_W(STEP_W), .LAST_STEP(LAST_STEP)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cycle_type (cycle_type),
  .step       (step),
  .ctl_ready  (ctl_ready),
  .cpu_irq    (cpu_irq)
);

// File: tb/test_bus_cycle_sequencer.sv
module test_bus_cycle_sequencer;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_hold = 0, ctl_dma_wr = 0, ctl_irq = 0, ctl_ready = 1;
  logic cpu_req = 0, bus_ready = 1;
  logic [2:0] cpu_op = 0;
  logic hold_ack, ctl_strobe, bus_req, bus_rw, bus_ds, cpu_irq, io_cycle;
  logic [3:0] cycle_type;
  logic [2:0] step;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bus_cycle_sequencer i_bus_cycle_sequencer (
    .clk(clk), .rst(rst), .ctl_hold(ctl_hold), .ctl_dma_wr(ctl_dma_wr),
    .ctl_irq(ctl_irq), .ctl_ready(ctl_ready), .cpu_req(cpu_req), .cpu_op(cpu_op),
    .bus_ready(bus_ready), .hold_ack(hold_ack), .ctl_strobe(ctl_strobe),
    .bus_req(bus_req), .bus_rw(bus_rw), .bus_ds(bus_ds), .cpu_irq(cpu_irq),
    .io_cycle(io_cycle), .cycle_type(cycle_type), .step(step)
  );

  // fields: irq, hold, dma_wr, cpu_req, cpu_op[2:0], expected code[3:0]
  localparam int NV = 10;
  localparam logic [10:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 4'd9},
    {1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 4'd6},
    {1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 4'd1},
    {1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 4'd2},
    {1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 4'd3},
    {1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 4'd4},
    {1'b0, 1'b0, 1'b0, 1'b1, 3'd4, 4'd5},
    {1'b1, 1'b1, 1'b0, 1'b1, 3'd2, 4'd9},
    {1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 4'd6},
    {1'b0, 1'b0, 1'b0, 1'b1, 3'd7, 4'd0}
  };

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic drop_all();
    ctl_irq = 0; ctl_hold = 0; cpu_req = 0;
  endtask

  task automatic wait_idle(input string rq);
    int n = 0;
    while (cycle_type != 4'd0 && n < 80) begin
      tick();
      n++;
    end
    chk(rq, int'(cycle_type), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    rst = 0;
    // R1: reset state
    chk("R1 code", int'(cycle_type), 0);
    chk("R1 step", int'(step), 0);
    chk("R1 handshakes", int'({hold_ack, bus_req, bus_ds, ctl_strobe, cpu_irq, io_cycle}), 0);

    // R2 R3 R10: table of requests from idle
    for (int v = 0; v < NV; v++) begin
      logic [3:0] exp;
      exp = VEC[v][3:0];
      {ctl_irq, ctl_hold, ctl_dma_wr, cpu_req, cpu_op} = VEC[v][10:4];
      tick();
      drop_all();
      chk($sformatf("R2 vector %0d code", v), int'(cycle_type), int'(exp));
      chk($sformatf("R3 vector %0d io_cycle", v), int'(io_cycle),
          int'(exp == 4'd1 || exp == 4'd2 || exp == 4'd5));
      if (exp == 4'd0)
        chk("R10 ignored op handshakes", int'({bus_req, ctl_strobe, hold_ack}), 0);
      wait_idle("R3 back to idle");
      tick();
    end

    // R10: unassigned op held for several clocks
    begin
      int bad = 0;
      cpu_req = 1; cpu_op = 3'd6;
      for (int k = 0; k < 6; k++) begin
        tick();
        if (cycle_type != 0 || bus_req || io_cycle || ctl_strobe) bad++;
      end
      drop_all();
      chk("R10 unassigned op stays idle", bad, 0);
    end

    // R8: controller-paced cycle waits on ctl_ready
    ctl_ready = 0; cpu_req = 1; cpu_op = 3'd2;
    tick();
    drop_all();
    chk("R8 ctl read started", int'(cycle_type), 3);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R8 step frozen", int'(step), 0);
      chk("R9 strobe low at step 0", int'(ctl_strobe), 0);
    end
    ctl_ready = 1;
    tick(); chk("R8 step 1", int'(step), 1);
    chk("R9 strobe", int'(ctl_strobe), 1);
    tick(); chk("R8 step 2", int'(step), 2);
    tick(); chk("R8 step 3", int'(step), 3);
    tick(); chk("R8 ends at last step", int'(cycle_type), 0);

    // R8: on-board cycle free-runs with both readies low
    ctl_ready = 0; bus_ready = 0; cpu_req = 1; cpu_op = 3'd0;
    tick();
    drop_all();
    chk("R8 local started", int'(cycle_type), 1);
    chk("R3 io flag", int'(io_cycle), 1);
    tick(); tick(); tick();
    chk("R8 local step 3", int'(step), 3);
    tick();
    chk("R8 local ends", int'(cycle_type), 0);
    ctl_ready = 1; bus_ready = 1;
    tick();

    // R4 R5 R9: burst of eight reads
    begin
      int starts = 0;
      ctl_hold = 1; ctl_dma_wr = 0;
      tick();
      chk("R4 sync first", int'(cycle_type), 6);
      chk("R9 bus_req in sync", int'(bus_req), 1);
      chk("R4 no hold_ack in sync", int'(hold_ack), 0);
      for (int k = 0; k < 80; k++) begin
        if (cycle_type == 4'd0) break;
        if (cycle_type == 4'd7 && step == 3'd0) begin
          starts++;
          if (starts == 1) begin
            chk("R4 hold_ack", int'(hold_ack), 1);
            chk("R9 bus_rw read", int'(bus_rw), 1);
          end
          if (starts == 8) ctl_hold = 0;
        end
        tick();
      end
      chk("R5 eight chained transfers", starts, 8);
      chk("R5 idle after hold drops", int'(cycle_type), 0);
    end
    tick();

    // R11 R9: CPU request waits behind a DMA write
    ctl_hold = 1; ctl_dma_wr = 1; cpu_req = 1; cpu_op = 3'd3;
    tick();
    ctl_hold = 0;
    chk("R11 DMA granted first", int'(cycle_type), 6);
    for (int k = 0; k < 20; k++) begin
      if (cycle_type != 4'd6) break;
      tick();
    end
    chk("R4 DMA write follows sync", int'(cycle_type), 8);
    chk("R9 bus_rw write", int'(bus_rw), 0);
    tick();
    chk("R9 bus_ds", int'(bus_ds), 1);
    for (int k = 0; k < 20; k++) begin
      if (cycle_type != 4'd8) break;
      tick();
    end
    chk("R11 idle before CPU cycle", int'(cycle_type), 0);
    tick();
    chk("R11 CPU cycle starts", int'(cycle_type), 4);
    drop_all();
    wait_idle("R3 CPU write ends");
    tick();

    // R6 R7: interrupt chain
    begin
      logic [3:0] seq [4];
      logic [3:0] prev;
      int n = 0;
      int irq_bad = 0;
      int in_wr = 0;
      ctl_irq = 1;
      tick();
      ctl_irq = 0;
      prev = cycle_type;
      seq[0] = cycle_type; n = 1;
      for (int k = 0; k < 60 && n < 4; k++) begin
        if (cpu_irq != (cycle_type == 4'd11)) irq_bad++;
        if (cycle_type == 4'd11) in_wr++;
        tick();
        if (cycle_type != prev) begin
          seq[n] = cycle_type; n++;
          prev = cycle_type;
        end
      end
      chk("R6 seq 0", int'(seq[0]), 9);
      chk("R6 seq 1", int'(seq[1]), 10);
      chk("R6 seq 2", int'(seq[2]), 11);
      chk("R6 seq 3", int'(seq[3]), 0);
      chk("R7 cpu_irq alignment", irq_bad, 0);
      chk("R7 cpu_irq clocks", in_wr, 4);
    end

    // R1: reset in the middle of a transfer
    ctl_hold = 1; ctl_dma_wr = 0;
    repeat (6) tick();
    rst = 1;
    tick();
    rst = 0; ctl_hold = 0;
    chk("R1 mid reset code", int'(cycle_type), 0);
    chk("R1 mid reset step", int'(step), 0);
    chk("R1 mid reset handshakes", int'({hold_ack, bus_req, bus_ds}), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule